// File: doc/BRIEF.md
# Register-Access Frame Decoder

This block sits behind a byte-level I2C target front end. It turns the byte stream of one bus transaction into a single register-access request. The front end supplies each received byte with a valid strobe, and marks start (or repeated start) and stop conditions with one-cycle markers. The decoder compares the first byte with a configured 7-bit target address and requires the direction bit to be zero. It then shifts in a three-byte control word that describes the access and collects a data field whose length the control word selects. When the control word asks for one, it also checks a trailing CRC-8 byte.

A completed frame produces a one-cycle request strobe, with the decoded fields and the packed data valid in the same cycle. A frame can fail in three ways. A reserved length code raises a length error. A CRC mismatch raises a CRC error. A marker that arrives early abandons the frame without any output. Because the control word sets both the data length and the presence of the CRC byte, the byte count of a frame is known only once the frame is under way.

Top module: `regframe_decoder`

## Requirements
- R1: A frame is made of an address byte {target[6:0], dir} followed by a control word of three bytes, sent most significant byte first. Bit 23 becomes `req_rd`, bit 22 `req_crc_en`, bits 21:20 `req_len`, bits 19:16 `req_sect`, bits 15:12 `req_page` and bits 11:0 `req_addr`. `req_valid` pulses high for exactly one cycle, in the cycle after the clock edge that takes the last byte of the frame.
- R2: The length code selects 2, 4 or 8 data bytes: 00 gives 2, 01 gives 4 and 10 gives 8. Data bytes arrive least significant byte first. Byte k lands in `req_data[8k+7:8k]`, and every bit above the received bytes reads zero.
- R3: Length code 11 raises `len_err` for one cycle, in the cycle after the edge that takes the first control byte. No request follows, and the rest of the frame is ignored until the next start marker.
- R4: When bit 22 is set, one CRC byte follows the data. If it matches, `req_valid` pulses one cycle after the edge that takes the CRC byte.
- R5: If the CRC byte does not match, `crc_err` pulses for one cycle in place of `req_valid`.
- R6: The CRC-8 uses polynomial 0x07 and initial value 0x00. It processes each byte most significant bit first, with no reflection and no final XOR. It covers the address byte, the three control bytes and all data bytes.
- R7: A stop marker that arrives before the last expected byte abandons the frame with no output. The decoder then ignores bytes until a start marker.
- R8: A start marker that arrives mid-frame abandons the frame with no output. The next byte is then treated as a fresh address byte.
- R9: If the address byte does not match `own_addr`, the decoder ignores every byte until the next start marker.
- R10: If the direction bit (address byte bit 0) is 1, the decoder ignores the frame.
- R11: After reset, `req_valid`, `crc_err`, `len_err` and `req_data` are all zero.
- R12: Bytes received after a completed frame, and bytes received with no preceding start marker, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 7 | Target address this decoder answers to |
| start_mark | input | 1 | One-cycle start or repeated-start marker |
| stop_mark | input | 1 | One-cycle stop marker |
| byte_valid | input | 1 | Qualifies byte_data for one cycle |
| byte_data | input | 8 | Received byte |
| req_valid | output | 1 | One-cycle request strobe |
| req_rd | output | 1 | Operation bit (control bit 23) |
| req_crc_en | output | 1 | CRC-enable bit (control bit 22) |
| req_len | output | 2 | Data-length code |
| req_sect | output | 4 | Memory section |
| req_page | output | 4 | Memory page |
| req_addr | output | 12 | Memory address |
| req_data | output | 64 | Packed data, upper unused bytes zero |
| crc_err | output | 1 | One-cycle CRC mismatch flag |
| len_err | output | 1 | One-cycle reserved length flag |

## Verification
A wrong byte counter or state register shows up at the ports within one frame. The strobe appears a byte early or late, or a frame of one length is taken for another. A scoreboard that expects exactly one event per frame catches either case at once. A corrupted CRC accumulator surfaces as a spurious `crc_err` on the very next CRC-enabled frame. A stale data lane shows as nonzero upper bits on the next short frame. Abort and ignore paths are checked by confirming that no event appears, and that a clean frame sent immediately afterward still decodes.

// File: rtl/regframe_pkg.sv
// Shared types and helpers for the register-access frame decoder.
// Assumes a fixed three-byte control word whose layout matches ctl_t.
package regframe_pkg;
    localparam int CTL_BYTES = 3;
    localparam int CTL_W     = CTL_BYTES * 8;
    localparam logic [1:0] LEN_RSVD = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_CTL, ST_DATA, ST_CRC
    } fsm_t;

    typedef struct packed {
        logic        rd;
        logic        crc_en;
        logic [1:0]  len;
        logic [3:0]  sect;
        logic [3:0]  page;
        logic [11:0] addr;
    } ctl_t;

    // One byte of an MSB-first, non-reflected CRC-8.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                             input logic [7:0] din,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc ^ din;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/regframe_crc8.sv
// Running CRC-8 accumulator, advanced one byte per update.
// restart makes the update start from INIT instead of the held value.
module regframe_crc8 #(
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       update,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import regframe_pkg::*;

    // Fold the incoming byte into the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc <= INIT;
        else if (update) crc <= crc8_step(restart ? INIT : crc, din, POLY);
    end
endmodule

// File: rtl/regframe_ctl_shift.sv
// Assembles the control word MSB byte first and presents its decoded fields.
// Assumes the caller asserts load exactly once per control byte.
module regframe_ctl_shift (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [7:0]             din,
    output regframe_pkg::ctl_t     fields
);
    import regframe_pkg::*;

    logic [CTL_W-1:0] sh;

    // Shift each control byte in from the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)    sh <= '0;
        else if (load) sh <= {sh[CTL_W-9:0], din};
    end

    assign fields = ctl_t'(sh);
endmodule

// File: rtl/regframe_data_pack.sv
// Places data bytes into byte lanes by index, LSB lane first.
// clear zeroes every lane so unused upper lanes read zero.
module regframe_data_pack #(
    parameter int MAX_BYTES = 8,
    parameter int IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   wr,
    input  logic [IDX_W-1:0]       idx,
    input  logic [7:0]             din,
    output logic [MAX_BYTES*8-1:0] data
);
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        // Hold one byte lane; load it when its index comes up.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                 data[g*8 +: 8] <= '0;
            else if (wr && idx == IDX_W'(g))     data[g*8 +: 8] <= din;
        end
    end
endmodule

// File: rtl/regframe_decoder.sv
// Register-access frame decoder. Consumes bytes and bus markers from a byte-level
// I2C target front end and emits one request per accepted frame.
// Assumes markers and byte_valid are single-cycle pulses. A marker in the same
// cycle as a byte takes priority and the byte is dropped.
module regframe_decoder #(
    parameter int          TGT_W          = 7,
    parameter int          DATA_MAX_BYTES = 8,
    parameter logic [7:0]  CRC_POLY       = 8'h07,
    parameter logic [7:0]  CRC_INIT       = 8'h00,
    localparam int         DATA_W         = DATA_MAX_BYTES * 8,
    localparam int         IDX_W          = $clog2(DATA_MAX_BYTES),
    localparam int         CNT_W          = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TGT_W-1:0]  own_addr,
    input  logic              start_mark,
    input  logic              stop_mark,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              req_valid,
    output logic              req_rd,
    output logic              req_crc_en,
    output logic [1:0]        req_len,
    output logic [3:0]        req_sect,
    output logic [3:0]        req_page,
    output logic [11:0]       req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              crc_err,
    output logic              len_err
);
    import regframe_pkg::*;

    fsm_t             state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic [7:0]       crc_q;
    ctl_t             ctl;
    logic             take;
    logic             addr_ok;

    assign take     = byte_valid && !start_mark && !stop_mark;
    assign addr_ok  = (byte_data[7:1] == own_addr) && !byte_data[0];
    assign last_idx = (CNT_W'(2) << ctl.len) - CNT_W'(1);

    regframe_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state == ST_ADDR),
        .update  (take && (state == ST_ADDR || state == ST_CTL || state == ST_DATA)),
        .din     (byte_data),
        .crc     (crc_q)
    );

    regframe_ctl_shift u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take && state == ST_CTL),
        .din    (byte_data),
        .fields (ctl)
    );

    regframe_data_pack #(.MAX_BYTES(DATA_MAX_BYTES), .IDX_W(IDX_W)) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (take && state == ST_ADDR && addr_ok),
        .wr    (take && state == ST_DATA),
        .idx   (cnt[IDX_W-1:0]),
        .din   (byte_data),
        .data  (req_data)
    );

    assign req_rd     = ctl.rd;
    assign req_crc_en = ctl.crc_en;
    assign req_len    = ctl.len;
    assign req_sect   = ctl.sect;
    assign req_page   = ctl.page;
    assign req_addr   = ctl.addr;

    // Frame sequencer: walks address, control, data and CRC, and raises the result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            req_valid <= 1'b0;
            crc_err   <= 1'b0;
            len_err   <= 1'b0;
        end else begin
            req_valid <= 1'b0;
            crc_err   <= 1'b0;
            len_err   <= 1'b0;
            if (start_mark) begin
                state <= ST_ADDR;
            end else if (stop_mark) begin
                state <= ST_IDLE;
            end else if (byte_valid) begin
                unique case (state)
                    ST_ADDR: begin
                        cnt   <= '0;
                        state <= addr_ok ? ST_CTL : ST_IDLE;
                    end
                    ST_CTL: begin
                        if (cnt == '0 && byte_data[5:4] == LEN_RSVD) begin
                            len_err <= 1'b1;
                            state   <= ST_IDLE;
                        end else if (cnt == CNT_W'(CTL_BYTES - 1)) begin
                            cnt   <= '0;
                            state <= ST_DATA;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_DATA: begin
                        if (cnt == last_idx) begin
                            if (ctl.crc_en) begin
                                state <= ST_CRC;
                            end else begin
                                req_valid <= 1'b1;
                                state     <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_CRC: begin
                        if (byte_data == crc_q) req_valid <= 1'b1;
                        else                    crc_err   <= 1'b1;
                        state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R1
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);
    // R1
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(byte_valid));
    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_len == 2'b00) |-> (req_data[DATA_W-1:16] == '0));
    // R3
    len_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != LEN_RSVD));
    // R3
    len_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (!req_valid && !crc_err));
    // R5
    crc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> (!req_valid && req_crc_en));
    // R7
    stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_mark) |-> !req_valid);
    // R8
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_mark) |-> (!req_valid && !crc_err));
endmodule

// File: tb/regframe_decoder_bench.sv
module regframe_decoder_bench;
    typedef enum logic [1:0] {EV_REQ, EV_CRC, EV_LEN} ev_t;
    typedef struct packed {
        ev_t         kind;
        logic        rd;
        logic        crc_en;
        logic [1:0]  len;
        logic [3:0]  sect;
        logic [3:0]  page;
        logic [11:0] addr;
        logic [63:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  own_addr = 7'h2C;
    logic        start_mark = 1'b0, stop_mark = 1'b0, byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        req_valid, req_rd, req_crc_en, crc_err, len_err;
    logic [1:0]  req_len;
    logic [3:0]  req_sect, req_page;
    logic [11:0] req_addr;
    logic [63:0] req_data;

    int   checks = 0, errors = 0, spurious = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    regframe_decoder u_regframe_decoder (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
        .start_mark(start_mark), .stop_mark(stop_mark),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .req_valid(req_valid), .req_rd(req_rd), .req_crc_en(req_crc_en),
        .req_len(req_len), .req_sect(req_sect), .req_page(req_page),
        .req_addr(req_addr), .req_data(req_data),
        .crc_err(crc_err), .len_err(len_err)
    );

    // Bitwise CRC-8, polynomial 0x07, init 0 (R6).
    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        for (int i = 0; i < 8; i++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
        return r;
    endfunction

    task automatic send_start();
        @(negedge clk); start_mark = 1'b1; @(negedge clk); start_mark = 1'b0;
    endtask
    task automatic send_stop();
        @(negedge clk); stop_mark = 1'b1; @(negedge clk); stop_mark = 1'b0;
    endtask
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    // Driver: pushes the expected event, then sends one whole frame.
    // crc_mode: 0 = no CRC byte sent, 1 = correct CRC, 2 = corrupted CRC.
    task automatic run_frame(input logic [6:0] a, input logic rw, input logic [23:0] cw,
                             input logic [63:0] d, input int crc_mode,
                             input bit expect_evt, input string tag);
        logic [7:0] c;
        int         n;
        exp_t       e;
        n = (cw[21:20] == 2'b11) ? 2 : (2 << cw[21:20]);
        if (expect_evt) begin
            e.rd = cw[23]; e.crc_en = cw[22]; e.len = cw[21:20];
            e.sect = cw[19:16]; e.page = cw[15:12]; e.addr = cw[11:0];
            e.data = (n == 8) ? d : (d & ((64'd1 << (8 * n)) - 64'd1));
            e.kind = (cw[21:20] == 2'b11) ? EV_LEN : ((crc_mode == 2) ? EV_CRC : EV_REQ);
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        send_start();
        c = crc_byte(8'h00, {a, rw});
        send_byte({a, rw});
        for (int k = 2; k >= 0; k--) begin
            c = crc_byte(c, cw[8*k +: 8]);
            send_byte(cw[8*k +: 8]);
        end
        for (int k = 0; k < n; k++) begin
            c = crc_byte(c, d[8*k +: 8]);
            send_byte(d[8*k +: 8]);
        end
        if (crc_mode == 1) send_byte(c);
        if (crc_mode == 2) send_byte(c ^ 8'h5A);
        send_stop();
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_quiet(input int mark, input string tag);
        repeat (3) @(negedge clk);
        checks++;
        if (spurious != mark || exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s quiet: events=%0d pending=%0d expected 0 0", tag,
                     spurious - mark, exp_q.size());
        end
    endtask

    // Monitor: pops the scoreboard whenever the design reports an event.
    always @(negedge clk) begin
        if (rst_n && !done && (req_valid || crc_err || len_err)) begin
            ev_t   got;
            exp_t  e;
            string t;
            got = req_valid ? EV_REQ : (crc_err ? EV_CRC : EV_LEN);
            if (exp_q.size() == 0) begin
                spurious++; checks++; errors++;
                $display("FAIL R12 unexpected event kind=%0d expected none", got);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (got != e.kind || ($countones({req_valid, crc_err, len_err}) != 1)) begin
                    errors++;
                    $display("FAIL %s kind=%0d expected %0d", t, got, e.kind);
                end else if (got == EV_REQ &&
                    ({req_rd, req_crc_en, req_len, req_sect, req_page, req_addr, req_data} !=
                     {e.rd, e.crc_en, e.len, e.sect, e.page, e.addr, e.data})) begin
                    errors++;
                    $display("FAIL %s fields=%h_%h expected %h_%h", t,
                        {req_rd, req_crc_en, req_len, req_sect, req_page, req_addr}, req_data,
                        {e.rd, e.crc_en, e.len, e.sect, e.page, e.addr}, e.data);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int mark;
        repeat (3) @(negedge clk);
        // R11: reset state
        checks++;
        if ({req_valid, crc_err, len_err} != 3'b000 || req_data != 64'd0) begin
            errors++;
            $display("FAIL R11 flags=%b data=%h expected 000 0", {req_valid, crc_err, len_err}, req_data);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: 16-bit write, no CRC
        run_frame(7'h2C, 1'b0, 24'h0_3_5ABC, 64'hFFEE_DDCC_BBAA_1234, 0, 1, "R1 R2 len16");
        // R1 R2: read op, 32-bit
        run_frame(7'h2C, 1'b0, 24'h9_7_1E01, 64'h1111_2222_8765_4321, 0, 1, "R1 R2 len32");
        // R2 R4 R6: 64-bit with good CRC
        run_frame(7'h2C, 1'b0, 24'h6_C_FFF0, 64'h0123_4567_89AB_CDEF, 1, 1, "R4 R6 len64 crc");
        // R2: short frame after long one must clear upper lanes
        run_frame(7'h2C, 1'b0, 24'hC_2_0777, 64'hAAAA_AAAA_AAAA_5A5A, 1, 1, "R2 R4 len16 crc");
        // R5: bad CRC
        run_frame(7'h2C, 1'b0, 24'h5_1_0042, 64'hDEAD_BEEF_CAFE_F00D, 2, 1, "R5 crc mismatch");
        // R3: reserved length code
        mark = spurious;
        run_frame(7'h2C, 1'b0, 24'h3_0_0001, 64'h0000_0000_0000_00FF, 0, 1, "R3 reserved len");
        expect_quiet(mark, "R3 remainder ignored");

        // R7: stop mid-data
        mark = spurious;
        send_start(); send_byte({7'h2C, 1'b0});
        send_byte(8'h10); send_byte(8'h00); send_byte(8'h00);
        send_byte(8'h11); send_stop();
        send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        expect_quiet(mark, "R7 stop abort");
        run_frame(7'h2C, 1'b0, 24'h2_4_0123, 64'h0000_0000_0000_BEEF, 0, 1, "R7 recovery");

        // R8: repeated start mid control word, then a full frame
        mark = spurious;
        send_start(); send_byte({7'h2C, 1'b0}); send_byte(8'h00);
        expect_quiet(mark, "R8 start abort");
        run_frame(7'h2C, 1'b0, 24'h1_9_0ABC, 64'h0000_0000_7766_5544, 0, 1, "R8 fresh frame");

        // R9: wrong target address
        mark = spurious;
        run_frame(7'h2D, 1'b0, 24'h0_0_0001, 64'h0000_0000_0000_1234, 0, 0, "R9");
        expect_quiet(mark, "R9 address mismatch");

        // R10: direction bit set
        mark = spurious;
        run_frame(7'h2C, 1'b1, 24'h0_0_0002, 64'h0000_0000_0000_5678, 0, 0, "R10");
        expect_quiet(mark, "R10 direction ignored");

        // R12: extra bytes after a finished frame, and bytes with no start
        mark = spurious;
        exp_q.push_back('{EV_REQ, 1'b0, 1'b0, 2'b00, 4'h0, 4'h0, 12'h003, 64'h0000_0000_0000_9988});
        tag_q.push_back("R12 base frame");
        send_start(); send_byte({7'h2C, 1'b0});
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h03);
        send_byte(8'h88); send_byte(8'h99);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h03); send_byte(8'h01); send_byte(8'h02);
        send_stop();
        send_byte({7'h2C, 1'b0}); send_byte(8'h00); send_byte(8'h00);
        send_byte(8'h03); send_byte(8'h01); send_byte(8'h02);
        expect_quiet(mark, "R12 trailing bytes");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule